// File: doc/BRIEF.md
# Three-wire synthesizer control register

This block is the serial programming port of a dual frequency synthesizer, one channel for transmit and one for receive. A controller shifts a fixed 23-bit frame into it over a serial data line, one bit per rising edge of a serial clock line. A rising edge on a load line then copies the frame into one of four holding latches. The two bits shifted in last pick the latch. The bit before them must be zero, or the frame is thrown away.

The four latches have different field layouts. The transmit reference latch holds a reference divide value, a monitor-output select, the prescaler select, the phase polarity and the charge-pump current select. The transmit counter latch holds the swallow and main counts. The receive reference latch holds a reference divide value, the fractional-modulus select, the spur-cancel setting, the polarity and the current select. The receive counter latch holds the swallow count, the main count and the fractional numerator. Every field is available at all times as a parallel output.

All three serial lines are asynchronous to the system clock `clk`. Each is passed through a `SYNC_STAGES`-deep synchronizer, and its edges are detected in the `clk` domain. A small control state machine commits or rejects each frame. Its states are:
- `ST_IDLE`: no bits accepted since the last load.
- `ST_COLLECT`: at least one bit accepted.
- `ST_COMMIT`: write the staged frame into the chosen latch.
- `ST_DISCARD`: drop the staged frame.

Its transitions are:
- IDLE→COLLECT on an accepted shift.
- IDLE or COLLECT→COMMIT on a load edge when frame bit 2 is 0.
- IDLE or COLLECT→DISCARD on a load edge when frame bit 2 is 1.
- COMMIT→IDLE and DISCARD→IDLE unconditionally.

Top module: `synth_ser_port`

## Requirements
- R1: Each accepted rising edge of `ser_clk` shifts the 23-bit register left by one and puts `ser_data` in bit 0. The first bit sent therefore ends in bit 22 (most significant bit first), and the last bit sent is bit 0.
- R2: On a rising edge of `ser_load`, the code {bit1, bit0} of the register picks exactly one latch: 00 transmit reference, 01 transmit counter, 10 receive reference, 11 receive counter. The other three latches keep their values.
- R3: A frame with bit 2 = 1 changes no latch.
- R4: Transmit reference layout:
  - bits 16:3 → `tx_ref_div`
  - bits 19:17 → `tx_mon_sel` (bit 17 in `tx_mon_sel[0]`)
  - bit 20 → `tx_pre_sel`
  - bit 21 → `tx_pol`
  - bit 22 → `tx_cp_hi`
- R5: Transmit counter layout: bits 7:3 → `tx_swallow`, bits 20:10 → `tx_main`. Bits 9:8 and 22:21 have no effect.
- R6: Receive reference layout:
  - bits 16:3 → `rx_ref_div`
  - bit 17 → `rx_mod8` (1 selects modulus 8, 0 selects modulus 5)
  - bits 19:18 → `rx_spur` (bit 18 in `rx_spur[0]`)
  - bit 21 → `rx_pol`
  - bit 22 → `rx_cp_hi`
  - bit 20 has no effect.
- R7: Receive counter layout: bits 7:3 → `rx_swallow`, bits 17:8 → `rx_main`, bits 21:18 → `rx_frac`. Bit 22 has no effect.
- R8: Rising edges of `ser_clk` while `ser_load` is high do not change the register.
- R9: A load edge after fewer than 23 new bits transfers the register as it stands: older bits move up by the number of new bits.
- R10: Reset clears every output to zero. A latch holds its value until a later frame addressed to it is committed.
- R11: A committed frame appears at the outputs within `SYNC_STAGES`+3 `clk` cycles of `ser_load` going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load strobe; its rising edge commits the frame |
| tx_ref_div | output | 14 | Transmit reference divide value |
| tx_mon_sel | output | 3 | Monitor output select |
| tx_pre_sel | output | 1 | Transmit prescaler select |
| tx_pol | output | 1 | Transmit phase polarity |
| tx_cp_hi | output | 1 | Transmit charge-pump high current |
| tx_swallow | output | 5 | Transmit swallow count |
| tx_main | output | 11 | Transmit main count |
| rx_ref_div | output | 14 | Receive reference divide value |
| rx_mod8 | output | 1 | Receive fractional modulus select |
| rx_spur | output | 2 | Receive spur-cancel setting |
| rx_pol | output | 1 | Receive phase polarity |
| rx_cp_hi | output | 1 | Receive charge-pump high current |
| rx_swallow | output | 5 | Receive swallow count |
| rx_main | output | 10 | Receive main count |
| rx_frac | output | 4 | Receive fractional numerator |

## Verification
Frames are sent for all four routing codes with different bit patterns, including all-ones and all-zeros payloads. Because every output is compared after every load, a misrouted frame, a wrong field position or a disturbed neighbour latch all show up. Two frames with bit 2 set, one of them all ones, separate a correct reject from a write. Two further cases separate the register from a simple frame counter:
- clocking while the load line is high, followed by a reload of an unchanged frame;
- a partial five-bit frame that relies on the older bits moving up.

// File: rtl/synth_port_pkg.sv
package synth_port_pkg;

    localparam int FRAME_W   = 23;
    localparam int SEL0_BIT  = 0;
    localparam int SEL1_BIT  = 1;
    localparam int BAD_BIT   = 2;
    localparam int FIELD_LSB = 3;
    localparam int REF_W     = 14;
    localparam int SWAL_W    = 5;
    localparam int TXMAIN_W  = 11;
    localparam int RXMAIN_W  = 10;
    localparam int FRAC_W    = 4;
    localparam int MON_W     = 3;
    localparam int SPUR_W    = 2;
    localparam int NUM_DEST  = 4;

    localparam int REF_MSB    = FIELD_LSB + REF_W - 1;
    localparam int SWAL_MSB   = FIELD_LSB + SWAL_W - 1;
    localparam int TXMAIN_LSB = 10;
    localparam int RXMAIN_LSB = SWAL_MSB + 1;
    localparam int FRAC_LSB   = RXMAIN_LSB + RXMAIN_W;
    localparam int FLAG_LSB   = REF_MSB + 1;

    typedef enum logic [1:0] {
        DEST_TX_REF = 2'b00,
        DEST_TX_CNT = 2'b01,
        DEST_RX_REF = 2'b10,
        DEST_RX_CNT = 2'b11
    } dest_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_COMMIT,
        ST_DISCARD
    } port_state_e;

    typedef struct packed {
        logic               cp_hi;
        logic               pol;
        logic               pre_sel;
        logic [MON_W-1:0]   mon_sel;
        logic [REF_W-1:0]   div;
    } tx_ref_t;

    typedef struct packed {
        logic [TXMAIN_W-1:0] main;
        logic [SWAL_W-1:0]   swallow;
    } tx_cnt_t;

    typedef struct packed {
        logic               cp_hi;
        logic               pol;
        logic [SPUR_W-1:0]  spur;
        logic               mod8;
        logic [REF_W-1:0]   div;
    } rx_ref_t;

    typedef struct packed {
        logic [FRAC_W-1:0]   frac;
        logic [RXMAIN_W-1:0] main;
        logic [SWAL_W-1:0]   swallow;
    } rx_cnt_t;

endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/sps_shift_reg.sv
module sps_shift_reg
    import synth_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_lvl,
    input  logic               din_lvl,
    input  logic               hold_lvl,
    output logic               shift_o,
    output logic [FRAME_W-1:0] word_o
);
    logic               sclk_prev_q;
    logic [FRAME_W-1:0] word_q;
    logic               shift_en;

    assign shift_en = sclk_lvl & ~sclk_prev_q & ~hold_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            word_q      <= '0;
        end else begin
            sclk_prev_q <= sclk_lvl;
            if (shift_en) word_q <= {word_q[FRAME_W-2:0], din_lvl};
        end
    end

    assign shift_o = shift_en;
    assign word_o  = word_q;

    // R1: newest bit enters at bit 0, the rest move up
    a_r1_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_q == {$past(word_q[FRAME_W-2:0]), $past(din_lvl)}));

    // R8: no change while the load line is high
    a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hold_lvl |=> $stable(word_q));
endmodule

// File: rtl/sps_latch_ctrl.sv
module sps_latch_ctrl
    import synth_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_lvl,
    input  logic               shift_i,
    input  logic [FRAME_W-1:0] word_i,
    output tx_ref_t            tx_ref_o,
    output tx_cnt_t            tx_cnt_o,
    output rx_ref_t            rx_ref_o,
    output rx_cnt_t            rx_cnt_o
);
    port_state_e        state_q, state_d;
    logic               load_prev_q;
    logic               load_rise;
    logic [FRAME_W-1:0] stage_q;
    dest_e              dest;
    logic [NUM_DEST-1:0] wr_en;

    tx_ref_t tx_ref_q;
    tx_cnt_t tx_cnt_q;
    rx_ref_t rx_ref_q;
    rx_cnt_t rx_cnt_q;

    assign load_rise = load_lvl & ~load_prev_q;
    assign dest      = dest_e'({stage_q[SEL1_BIT], stage_q[SEL0_BIT]});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            load_prev_q <= 1'b0;
            stage_q     <= '0;
        end else begin
            state_q     <= state_d;
            load_prev_q <= load_lvl;
            if (load_rise) stage_q <= word_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_COLLECT: begin
                if (load_rise)
                    state_d = word_i[BAD_BIT] ? ST_DISCARD : ST_COMMIT;
                else if (shift_i)
                    state_d = ST_COLLECT;
            end
            ST_COMMIT:  state_d = ST_IDLE;
            ST_DISCARD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs: one write strobe per latch
    always_comb begin
        wr_en = '0;
        if (state_q == ST_COMMIT) wr_en[dest] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ref_q <= '0;
            tx_cnt_q <= '0;
            rx_ref_q <= '0;
            rx_cnt_q <= '0;
        end else begin
            if (wr_en[DEST_TX_REF]) begin
                tx_ref_q.div     <= stage_q[REF_MSB:FIELD_LSB];
                tx_ref_q.mon_sel <= stage_q[FLAG_LSB+MON_W-1:FLAG_LSB];
                tx_ref_q.pre_sel <= stage_q[FLAG_LSB+3];
                tx_ref_q.pol     <= stage_q[FLAG_LSB+4];
                tx_ref_q.cp_hi   <= stage_q[FLAG_LSB+5];
            end
            if (wr_en[DEST_TX_CNT]) begin
                tx_cnt_q.swallow <= stage_q[SWAL_MSB:FIELD_LSB];
                tx_cnt_q.main    <= stage_q[TXMAIN_LSB+TXMAIN_W-1:TXMAIN_LSB];
            end
            if (wr_en[DEST_RX_REF]) begin
                rx_ref_q.div   <= stage_q[REF_MSB:FIELD_LSB];
                rx_ref_q.mod8  <= stage_q[FLAG_LSB];
                rx_ref_q.spur  <= stage_q[FLAG_LSB+SPUR_W:FLAG_LSB+1];
                rx_ref_q.pol   <= stage_q[FLAG_LSB+4];
                rx_ref_q.cp_hi <= stage_q[FLAG_LSB+5];
            end
            if (wr_en[DEST_RX_CNT]) begin
                rx_cnt_q.swallow <= stage_q[SWAL_MSB:FIELD_LSB];
                rx_cnt_q.main    <= stage_q[RXMAIN_LSB+RXMAIN_W-1:RXMAIN_LSB];
                rx_cnt_q.frac    <= stage_q[FRAC_LSB+FRAC_W-1:FRAC_LSB];
            end
        end
    end

    assign tx_ref_o = tx_ref_q;
    assign tx_cnt_o = tx_cnt_q;
    assign rx_ref_o = rx_ref_q;
    assign rx_cnt_o = rx_cnt_q;

    // R2: at most one latch written per commit
    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R2: a transmit-reference commit leaves the other latches alone
    a_r2_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && dest == DEST_TX_REF)
        |=> ($stable(tx_cnt_q) && $stable(rx_ref_q) && $stable(rx_cnt_q)));

    // R3: a rejected frame leaves every latch unchanged
    a_r3_discard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD)
        |=> ($stable(tx_ref_q) && $stable(tx_cnt_q) && $stable(rx_ref_q) && $stable(rx_cnt_q)));

    // R11: a commit or discard lasts one cycle
    a_r11_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT || state_q == ST_DISCARD) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/synth_ser_port.sv
module synth_ser_port
    import synth_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_load,
    output logic [13:0] tx_ref_div,
    output logic [2:0]  tx_mon_sel,
    output logic        tx_pre_sel,
    output logic        tx_pol,
    output logic        tx_cp_hi,
    output logic [4:0]  tx_swallow,
    output logic [10:0] tx_main,
    output logic [13:0] rx_ref_div,
    output logic        rx_mod8,
    output logic [1:0]  rx_spur,
    output logic        rx_pol,
    output logic        rx_cp_hi,
    output logic [4:0]  rx_swallow,
    output logic [9:0]  rx_main,
    output logic [3:0]  rx_frac
);
    logic               sclk_lvl, din_lvl, load_lvl;
    logic               shift_pulse;
    logic [FRAME_W-1:0] word;
    tx_ref_t            tx_ref;
    tx_cnt_t            tx_cnt;
    rx_ref_t            rx_ref;
    rx_cnt_t            rx_cnt;

    sps_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .async_i(ser_clk), .level_o(sclk_lvl));
    sps_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .async_i(ser_data), .level_o(din_lvl));
    sps_sync #(.STAGES(SYNC_STAGES)) u_sync_ld (
        .clk(clk), .rst_n(rst_n), .async_i(ser_load), .level_o(load_lvl));

    sps_shift_reg u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl), .din_lvl(din_lvl),
        .hold_lvl(load_lvl), .shift_o(shift_pulse), .word_o(word));

    sps_latch_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_lvl(load_lvl), .shift_i(shift_pulse),
        .word_i(word), .tx_ref_o(tx_ref), .tx_cnt_o(tx_cnt),
        .rx_ref_o(rx_ref), .rx_cnt_o(rx_cnt));

    assign tx_ref_div = tx_ref.div;
    assign tx_mon_sel = tx_ref.mon_sel;
    assign tx_pre_sel = tx_ref.pre_sel;
    assign tx_pol     = tx_ref.pol;
    assign tx_cp_hi   = tx_ref.cp_hi;
    assign tx_swallow = tx_cnt.swallow;
    assign tx_main    = tx_cnt.main;
    assign rx_ref_div = rx_ref.div;
    assign rx_mod8    = rx_ref.mod8;
    assign rx_spur    = rx_ref.spur;
    assign rx_pol     = rx_ref.pol;
    assign rx_cp_hi   = rx_ref.cp_hi;
    assign rx_swallow = rx_cnt.swallow;
    assign rx_main    = rx_cnt.main;
    assign rx_frac    = rx_cnt.frac;
endmodule

// File: tb/synth_ser_port_tb.sv
module synth_ser_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int NVEC = 8;
    localparam logic [22:0] VEC [NVEC] = '{
        23'h2A5A78, 23'h3C3C39, 23'h6B1D42, 23'h55AA5B,
        23'h7FFFFC, 23'h12345F, 23'h7FFFF8, 23'h000003 };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [13:0] tx_ref_div, rx_ref_div;
    logic [2:0]  tx_mon_sel;
    logic        tx_pre_sel, tx_pol, tx_cp_hi, rx_mod8, rx_pol, rx_cp_hi;
    logic [4:0]  tx_swallow, rx_swallow;
    logic [10:0] tx_main;
    logic [1:0]  rx_spur;
    logic [9:0]  rx_main;
    logic [3:0]  rx_frac;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [22:0] shadow;
    logic [22:0] e_txr, e_txc, e_rxr, e_rxc;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_ser_port #(.SYNC_STAGES(SYNC)) dut_i (.*);

    task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "R4 tx_ref_div", 32'(tx_ref_div), 32'(e_txr[16:3]));
        chk(tag, "R4 tx_mon_sel", 32'(tx_mon_sel), 32'(e_txr[19:17]));
        chk(tag, "R4 tx_pre_sel", 32'(tx_pre_sel), 32'(e_txr[20]));
        chk(tag, "R4 tx_pol",     32'(tx_pol),     32'(e_txr[21]));
        chk(tag, "R4 tx_cp_hi",   32'(tx_cp_hi),   32'(e_txr[22]));
        chk(tag, "R5 tx_swallow", 32'(tx_swallow), 32'(e_txc[7:3]));
        chk(tag, "R5 tx_main",    32'(tx_main),    32'(e_txc[20:10]));
        chk(tag, "R6 rx_ref_div", 32'(rx_ref_div), 32'(e_rxr[16:3]));
        chk(tag, "R6 rx_mod8",    32'(rx_mod8),    32'(e_rxr[17]));
        chk(tag, "R6 rx_spur",    32'(rx_spur),    32'(e_rxr[19:18]));
        chk(tag, "R6 rx_pol",     32'(rx_pol),     32'(e_rxr[21]));
        chk(tag, "R6 rx_cp_hi",   32'(rx_cp_hi),   32'(e_rxr[22]));
        chk(tag, "R7 rx_swallow", 32'(rx_swallow), 32'(e_rxc[7:3]));
        chk(tag, "R7 rx_main",    32'(rx_main),    32'(e_rxc[17:8]));
        chk(tag, "R7 rx_frac",    32'(rx_frac),    32'(e_rxc[21:18]));
    endtask

    // R2/R3 model of routing
    task automatic model_load(input logic [22:0] w);
        if (!w[2]) begin
            case ({w[1], w[0]})
                2'b00: e_txr = w;
                2'b01: e_txc = w;
                2'b10: e_rxr = w;
                default: e_rxc = w;
            endcase
        end
    endtask

    task automatic send_bits(input logic [22:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) ser_data = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            shadow = {shadow[21:0], w[i]};
        end
    endtask

    // R11: sample SYNC+3 cycles after the load line rises
    task automatic do_load(input string tag);
        @(negedge clk) ser_load = 1'b1;
        repeat (SYNC + 3) @(negedge clk);
        model_load(shadow);
        check_all(tag);
        repeat (3) @(negedge clk);
        ser_load = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        shadow = '0; e_txr = '0; e_txc = '0; e_rxr = '0; e_rxc = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R10 reset");

        // table walk: R1 R2 R3 R4 R5 R6 R7 R11
        for (int v = 0; v < NVEC; v++) begin
            send_bits(VEC[v], 23);
            do_load(VEC[v][2] ? "R3 reject" : "R2 route");
        end

        // R8: clocking with load held high does not alter the register
        send_bits(23'h2A5A78, 23);
        do_load("R8 pre");
        @(negedge clk) ser_load = 1'b1;
        repeat (6) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            ser_data = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        ser_load = 1'b0;
        repeat (6) @(negedge clk);
        e_txr = '0;
        do_load("R8 reload");
        chk("R8", "tx_ref_div kept", 32'(tx_ref_div), 32'(23'h2A5A78 >> 3) & 32'h3FFF);

        // R9: partial frame of five bits
        send_bits(23'h000003, 23);
        do_load("R9 base");
        send_bits(23'h000019, 5);
        do_load("R9 partial");
        chk("R9", "tx_swallow", 32'(tx_swallow), 32'd15);

        // R10: reset mid-run clears everything
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_txr = '0; e_txc = '0; e_rxr = '0; e_rxc = '0; shadow = '0;
        @(negedge clk);
        check_all("R10 re-reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule